// File: doc/BRIEF.md
# Iterative Bit-Serial Shifter

This block shifts a data word left or right by a variable number of positions, moving it one position per clock cycle rather than through a barrel shifter. A caller pulses `start` with an operand, a shift amount and a mode. The unit then runs on its own and answers with a one-cycle `done` pulse. The result stays on `result_o` until the next operation completes.

Internally the shift amount goes into a down-counter. The operand is copied unchanged into a working register. Each loop pass shifts that register by one position and decrements the counter in the same cycle, and the loop ends when the counter reaches zero. A zero amount bypasses the loop entirely. The bit that enters the vacated end on each step is chosen by the mode. For the arithmetic mode it is the sign bit of the captured operand, which stays on hand for the whole run.

Top module: `iter_shifter`

## Requirements
- R1: After synchronous reset, `done_o` is 0 and `result_o` is 0.
- R2: Mode code 0 is a logical left shift: every step moves the word up one place and a 0 enters bit 0.
- R3: Mode codes 1 and 3 are a logical right shift: every step moves the word down one place and a 0 enters the top bit.
- R4: Mode code 2 is an arithmetic right shift: every step moves the word down one place and the top bit of the operand captured at start enters the top bit.
- R5: An amount of 0 returns the operand unchanged, with `done_o` high in the cycle that follows the second rising edge after the accepting edge.
- R6: For an amount n > 0, `done_o` appears n+2 rising edges after the edge that accepted `start`, and `result_o` equals the operand shifted n places.
- R7: An amount of WIDTH or more yields all zeros in modes 0, 1 and 3, and all copies of the operand's top bit in mode 2.
- R8: `done_o` is high for exactly one cycle per operation, and `result_o` holds its value from that cycle until the next operation completes.
- R9: A `start` asserted while an operation is in progress is ignored: the running result is unaffected and no extra `done_o` pulse follows.
- R10: The operand, amount and mode are sampled only at the accepting edge; changes to them during the run do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation (taken only when idle) |
| operand_i | input | WIDTH | Word to shift |
| amount_i | input | WIDTH | Number of positions to shift |
| mode_i | input | 2 | 0 left logical, 1 or 3 right logical, 2 right arithmetic |
| result_o | output | WIDTH | Shifted word, held between operations |
| done_o | output | 1 | One-cycle pulse when `result_o` is updated |

## Verification
The bench builds the block with the default WIDTH of 16. This keeps a shift by width-1, by exactly the width and by a few positions beyond it within about twenty loop passes, so the fill boundary and the all-fill results are both reached quickly. Random operands over all four mode codes and amounts from 0 to 19 are checked against a reference shift, and the latency is compared on every operation. Directed runs pulse `start` and change the inputs during a busy run to show they are ignored.

// File: rtl/shf_pkg.sv
package shf_pkg;

    typedef enum logic [1:0] {
        SHM_LEFT  = 2'd0,
        SHM_RIGHT = 2'd1,
        SHM_ARITH = 2'd2,
        SHM_RALT  = 2'd3
    } shf_mode_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_PREP  = 2'd1,
        SQ_SHIFT = 2'd2,
        SQ_FIN   = 2'd3
    } shf_state_e;

    typedef struct packed {
        logic cnt_load;
        logic cnt_dec;
        logic acc_capture;
        logic acc_prep;
        logic acc_step;
        logic res_load;
    } shf_ctl_t;

    function automatic logic goes_left(input shf_mode_e m);
        return m == SHM_LEFT;
    endfunction

    function automatic logic fill_for(input shf_mode_e m, input logic sign);
        return (m == SHM_ARITH) ? sign : 1'b0;
    endfunction

endpackage

// File: rtl/shf_countdown.sv
module shf_countdown #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             inc,
    input  logic             dec,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] cnt_q
);

    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= din;
        end else if (inc) begin
            cnt_q <= cnt_q + ONE;
        end else if (dec) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    // load outranks the step commands
    a_cnt_load_first: assert property (@(posedge clk) disable iff (rst)
        load |=> cnt_q == $past(din));

    // R6: a lone decrement consumes exactly one position
    a_r6_dec_one: assert property (@(posedge clk) disable iff (rst)
        (dec && !load && !inc) |=> cnt_q == $past(cnt_q) - ONE);

endmodule

// File: rtl/shf_accum.sv
module shf_accum
    import shf_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic             prep,
    input  logic             step,
    input  logic [WIDTH-1:0] operand_i,
    input  logic [1:0]       mode_i,
    output logic [WIDTH-1:0] acc_q
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] op_q;
    shf_mode_e        mode_q;
    logic             fill;
    logic [WIDTH-1:0] stepped;

    assign fill = fill_for(mode_q, op_q[MSB]);

    always_comb begin
        if (goes_left(mode_q)) begin
            stepped = {acc_q[MSB-1:0], fill};
        end else begin
            stepped = {fill, acc_q[MSB:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= '0;
            mode_q <= SHM_LEFT;
            acc_q  <= '0;
        end else begin
            if (capture) begin
                op_q   <= operand_i;
                mode_q <= shf_mode_e'(mode_i);
            end
            if (prep) begin
                acc_q <= op_q;
            end else if (step) begin
                acc_q <= stepped;
            end
        end
    end

    // R2: left step brings a zero into bit 0
    a_r2_left_zero_in: assert property (@(posedge clk) disable iff (rst)
        (step && !prep && mode_q == SHM_LEFT) |=> acc_q[0] == 1'b0);

    // R3: logical right step brings a zero into the top bit
    a_r3_right_zero_in: assert property (@(posedge clk) disable iff (rst)
        (step && !prep && (mode_q == SHM_RIGHT || mode_q == SHM_RALT))
            |=> acc_q[MSB] == 1'b0);

    // R4: arithmetic step refills with the captured sign
    a_r4_sign_in: assert property (@(posedge clk) disable iff (rst)
        (step && !prep && !capture && mode_q == SHM_ARITH)
            |=> acc_q[MSB] == $past(op_q[MSB]));

endmodule

// File: rtl/shf_seq.sv
module shf_seq
    import shf_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     cnt_zero,
    input  logic     cnt_one,
    output shf_ctl_t ctl,
    output logic     done_q
);

    shf_state_e state_q;
    shf_state_e state_d;

    always_comb begin
        state_d = state_q;
        ctl     = '0;
        unique case (state_q)
            SQ_IDLE: begin
                if (start) begin
                    ctl.cnt_load    = 1'b1;
                    ctl.acc_capture = 1'b1;
                    state_d         = SQ_PREP;
                end
            end
            SQ_PREP: begin
                ctl.acc_prep = 1'b1;
                state_d      = cnt_zero ? SQ_FIN : SQ_SHIFT;
            end
            SQ_SHIFT: begin
                ctl.acc_step = 1'b1;
                ctl.cnt_dec  = 1'b1;
                if (cnt_one) begin
                    state_d = SQ_FIN;
                end
            end
            SQ_FIN: begin
                ctl.res_load = 1'b1;
                state_d      = SQ_IDLE;
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= ctl.res_load;
        end
    end

    // R5: a zero count goes straight to write-back
    a_r5_zero_skip: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_PREP && cnt_zero) |=> state_q == SQ_FIN);

    // R8: completion is a single-cycle pulse
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R9: a busy unit never restarts
    a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
        (state_q != SQ_IDLE && start) |=> state_q != SQ_PREP);

endmodule

// File: rtl/iter_shifter.sv
module iter_shifter
    import shf_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] operand_i,
    input  logic [WIDTH-1:0] amount_i,
    input  logic [1:0]       mode_i,
    output logic [WIDTH-1:0] result_o,
    output logic             done_o
);

    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    shf_ctl_t         ctl;
    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] acc_q;
    logic [WIDTH-1:0] result_q;

    shf_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cnt_zero (cnt_q == '0),
        .cnt_one  (cnt_q == ONE),
        .ctl      (ctl),
        .done_q   (done_o)
    );

    shf_countdown #(.WIDTH(WIDTH)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .load  (ctl.cnt_load),
        .inc   (1'b0),
        .dec   (ctl.cnt_dec),
        .din   (amount_i),
        .cnt_q (cnt_q)
    );

    shf_accum #(.WIDTH(WIDTH)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .capture   (ctl.acc_capture),
        .prep      (ctl.acc_prep),
        .step      (ctl.acc_step),
        .operand_i (operand_i),
        .mode_i    (mode_i),
        .acc_q     (acc_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
        end else if (ctl.res_load) begin
            result_q <= acc_q;
        end
    end

    assign result_o = result_q;

    // R8: the result only moves together with a done pulse
    a_r8_result_hold: assert property (@(posedge clk) disable iff (rst)
        !$stable(result_q) |-> done_o);

endmodule

// File: tb/tb_iter_shifter.sv
module tb_iter_shifter;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] operand = '0;
    logic [W-1:0] amount = '0;
    logic [1:0]   mode = 2'd0;
    logic [W-1:0] result;
    logic         done;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #2 clk = ~clk;

    iter_shifter #(.WIDTH(W)) dut (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .operand_i (operand),
        .amount_i  (amount),
        .mode_i    (mode),
        .result_o  (result),
        .done_o    (done)
    );

    function automatic logic [W-1:0] ref_shift(input logic [W-1:0] op,
                                               input logic [W-1:0] amt,
                                               input logic [1:0]   md);
        logic [W-1:0] v = op;
        int n = (amt > W) ? W : int'(amt);
        for (int i = 0; i < n; i++) begin
            if (md == 2'd0)      v = {v[W-2:0], 1'b0};
            else if (md == 2'd2) v = {op[W-1], v[W-1:1]};
            else                 v = {1'b0, v[W-1:1]};
        end
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Runs one operation; if disturb is set, pulses start with junk and
    // scrambles the inputs while the unit is busy.
    task automatic run_op(input logic [W-1:0] op, input logic [W-1:0] amt,
                          input logic [1:0] md, input bit disturb,
                          input string req);
        logic [W-1:0] exp = ref_shift(op, amt, md);
        int lat = 0;
        @(negedge clk);
        operand = op; amount = amt; mode = md; start = 1'b1;
        @(posedge clk);
        forever begin
            @(negedge clk);
            start = 1'b0;
            if (disturb && lat >= 1) begin
                operand = ~op; amount = amt + 16'd3; mode = md ^ 2'd1;
                start = 1'b1;
            end
            if (done) break;
            @(posedge clk);
            lat++;
            if (lat > 400) begin
                check(1'b0, req, "watchdog latency", lat, int'(amt) + 2);
                break;
            end
        end
        start = 1'b0;
        check(result == exp, req, "result", result, exp);
        check(lat == int'(amt) + 2, "R6", "latency", lat, int'(amt) + 2);
        operand = ~operand; amount = 16'd5;
        @(negedge clk);
        check(done == 1'b0, "R8", "done pulse length", done, 0);
        check(result == exp, "R8", "result held", result, exp);
        if (disturb) begin
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                check(done == 1'b0, "R9", "no extra done", done, 0);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R1", "done after reset", done, 0);
        check(result == '0, "R1", "result after reset", result, 0);
        rst = 1'b0;

        // R5: zero amount returns the operand
        run_op(16'hA5C3, 16'd0, 2'd0, 1'b0, "R5");
        run_op(16'h8001, 16'd0, 2'd2, 1'b0, "R5");
        // R2 / R3 / R4 directed
        run_op(16'h8001, 16'd1, 2'd0, 1'b0, "R2");
        run_op(16'h0001, 16'd15, 2'd0, 1'b0, "R2");
        run_op(16'h8001, 16'd1, 2'd1, 1'b0, "R3");
        run_op(16'hF0F0, 16'd4, 2'd3, 1'b0, "R3");
        run_op(16'h8000, 16'd15, 2'd2, 1'b0, "R4");
        run_op(16'h9234, 16'd3, 2'd2, 1'b0, "R4");
        run_op(16'h7234, 16'd3, 2'd2, 1'b0, "R4");
        // R7: width and beyond
        run_op(16'hFFFF, 16'd16, 2'd0, 1'b0, "R7");
        run_op(16'hFFFF, 16'd16, 2'd1, 1'b0, "R7");
        run_op(16'h8F00, 16'd16, 2'd2, 1'b0, "R7");
        run_op(16'h4F00, 16'd19, 2'd2, 1'b0, "R7");
        run_op(16'hBEEF, 16'd200, 2'd0, 1'b0, "R7");
        // R9 / R10: busy start and input changes ignored
        run_op(16'hC3A5, 16'd6, 2'd2, 1'b1, "R9");
        run_op(16'h1234, 16'd0, 2'd0, 1'b1, "R10");
        run_op(16'h8421, 16'd9, 2'd1, 1'b1, "R10");
        // random mix
        for (int i = 0; i < 60; i++) begin
            logic [W-1:0] op  = W'($urandom);
            logic [W-1:0] amt = W'($urandom % 20);
            logic [1:0]   md  = 2'($urandom % 4);
            run_op(op, amt, md, 1'b0, "R6");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual %0d expected below 150000", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
                $finish;
            end
        end
    end

endmodule